// File: doc/BRIEF.md
# Exception Arbiter and Vector Generator

This block looks at every exception request that is pending in a cycle and picks one. The candidates are three requests raised inside the core (debug, illegal instruction, trap), one non-maskable external interrupt, and one maskable external interrupt that carries a 3-bit priority level. The choice follows a fixed order of exception classes. The maskable interrupt first passes a separate masking test: its level is compared against the mask threshold taken from the status register.

On the clock edge after the requests are presented, the block raises a take strobe for one cycle. With the strobe it gives a class identifier and the vector offset the sequencer should jump through. Each internal exception has its own vector offset, set by a parameter. The two external interrupts each have a select input. It picks either a fixed auto-vector or a 6-bit offset from the interrupt controller, shifted left by three bits. Stacking, status updates and the jump itself belong to the logic that consumes these outputs.

Top module: `exc_vector_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `take` is 0, `exc_id` is 0 and `vec_off` is 0.
- R2: A debug request is always taken, whatever else is pending, with `exc_id` = 0 and `vec_off` = DBG_VEC (default 0x040).
- R3: An illegal-instruction request, without debug, is taken with `exc_id` = 1 and `vec_off` = ILL_VEC (default 0x080), ahead of trap and both external interrupts.
- R4: A trap request, without debug or illegal, is taken with `exc_id` = 2 and `vec_off` = TRAP_VEC (default 0x0C0), ahead of both external interrupts.
- R5: A non-maskable interrupt, with no internal request, is taken with `exc_id` = 4 ahead of any maskable interrupt, whatever the maskable interrupt's level.
- R6: A maskable interrupt is eligible only when `irq_level` is strictly greater than `sr_mask`. When it is taken alone, `exc_id` = 5. A level equal to or below the mask produces no take.
- R7: The non-maskable vector is 0x180 when `nmi_autovec` is 1, and `irq_offset` << 3 when it is 0.
- R8: The maskable vector is 0x1C0 when `irq_autovec` is 1, and `irq_offset` << 3 when it is 0.
- R9: Outputs are registered. A take appears on the cycle after the requests are sampled and lasts for one cycle per sampled cycle. If no request is eligible, `take` is 0, and `exc_id` and `vec_off` return to 0.
- R10: Class identifier 3 is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Debug exception pending |
| ill_req | input | 1 | Illegal-instruction exception pending |
| trap_req | input | 1 | Trap exception pending |
| nmi_req | input | 1 | Non-maskable external interrupt pending |
| nmi_autovec | input | 1 | 1: NMI uses its auto-vector; 0: uses the offset input |
| irq_req | input | 1 | Maskable external interrupt pending |
| irq_level | input | 3 | Priority level of the maskable interrupt |
| irq_autovec | input | 1 | 1: maskable interrupt uses its auto-vector; 0: uses the offset input |
| irq_offset | input | 6 | Offset from the external interrupt controller |
| sr_mask | input | 3 | Mask threshold from the status register |
| take | output | 1 | Exception taken this cycle |
| exc_id | output | 3 | Class of the taken exception |
| vec_off | output | 9 | Vector offset of the taken exception |

## Verification
Every result is due exactly one clock after the requests are presented, because the selection passes through one register stage. The bench drives a new input set on each falling edge. On the next falling edge it compares all three outputs against a behavioural model, which it evaluates on the values driven one cycle earlier. Directed sets cover each priority pair, the mask boundary at equal and one-above levels, and both vector sources. Random sets fill in the rest.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

   typedef enum logic [2:0] {
      EXC_DEBUG   = 3'd0,
      EXC_ILLEGAL = 3'd1,
      EXC_TRAP    = 3'd2,
      EXC_NMI     = 3'd4,
      EXC_IRQ     = 3'd5
   } exc_id_e;

   localparam int NUM_CLASSES = 6;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
   parameter int LVL_W     = 3,
   parameter bit STRICT_GT = 1'b1
) (
   input  logic             irq_req,
   input  logic [LVL_W-1:0] irq_level,
   input  logic [LVL_W-1:0] sr_mask,
   output logic             irq_ok
);

   generate
      if (STRICT_GT) begin : g_strict
         assign irq_ok = irq_req && (irq_level > sr_mask);
      end else begin : g_incl
         assign irq_ok = irq_req && (irq_level >= sr_mask);
      end
   endgenerate

endmodule

// File: rtl/exc_prio_select.sv
module exc_prio_select
   import exc_arb_pkg::*;
#(
   parameter int N = NUM_CLASSES
) (
   input  logic [N-1:0] req_vec,
   output logic         any_req,
   output exc_id_e      winner
);

   logic [N-1:0] blocked;

   // blocked[i] is set when some class numbered below i is pending
   assign blocked[0] = 1'b0;
   generate
      for (genvar i = 1; i < N; i++) begin : g_chain
         assign blocked[i] = blocked[i-1] | req_vec[i-1];
      end
   endgenerate

   always_comb begin
      winner  = EXC_DEBUG;
      any_req = |req_vec;
      for (int i = 0; i < N; i++) begin
         if (req_vec[i] && !blocked[i]) winner = exc_id_e'(i[2:0]);
      end
   end

endmodule

// File: rtl/exc_vec_mux.sv
module exc_vec_mux
   import exc_arb_pkg::*;
#(
   parameter int VEC_W     = 9,
   parameter int OFS_W     = 6,
   parameter int OFS_SHIFT = 3,
   parameter int DBG_VEC   = 'h040,
   parameter int ILL_VEC   = 'h080,
   parameter int TRAP_VEC  = 'h0C0,
   parameter int NMI_AUTO  = 'h180,
   parameter int IRQ_AUTO  = 'h1C0
) (
   input  exc_id_e          sel,
   input  logic             nmi_autovec,
   input  logic             irq_autovec,
   input  logic [OFS_W-1:0] irq_offset,
   output logic [VEC_W-1:0] vec
);

   localparam int PAD_W = VEC_W - OFS_W - OFS_SHIFT;

   logic [VEC_W-1:0] ext_vec;

   generate
      if (PAD_W > 0) begin : g_pad
         assign ext_vec = {{PAD_W{1'b0}}, irq_offset, {OFS_SHIFT{1'b0}}};
      end else begin : g_nopad
         assign ext_vec = {irq_offset, {OFS_SHIFT{1'b0}}};
      end
   endgenerate

   always_comb begin
      unique case (sel)
         EXC_DEBUG:   vec = VEC_W'(DBG_VEC);
         EXC_ILLEGAL: vec = VEC_W'(ILL_VEC);
         EXC_TRAP:    vec = VEC_W'(TRAP_VEC);
         EXC_NMI:     vec = nmi_autovec ? VEC_W'(NMI_AUTO) : ext_vec;
         EXC_IRQ:     vec = irq_autovec ? VEC_W'(IRQ_AUTO) : ext_vec;
         default:     vec = '0;
      endcase
   end

endmodule

// File: rtl/exc_vector_arbiter.sv
module exc_vector_arbiter
   import exc_arb_pkg::*;
#(
   parameter int LVL_W     = 3,
   parameter int OFS_W     = 6,
   parameter int OFS_SHIFT = 3,
   parameter int VEC_W     = 9,
   parameter int DBG_VEC   = 'h040,
   parameter int ILL_VEC   = 'h080,
   parameter int TRAP_VEC  = 'h0C0,
   parameter int NMI_AUTO  = 'h180,
   parameter int IRQ_AUTO  = 'h1C0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbg_req,
   input  logic             ill_req,
   input  logic             trap_req,
   input  logic             nmi_req,
   input  logic             nmi_autovec,
   input  logic             irq_req,
   input  logic [LVL_W-1:0] irq_level,
   input  logic             irq_autovec,
   input  logic [OFS_W-1:0] irq_offset,
   input  logic [LVL_W-1:0] sr_mask,
   output logic             take,
   output logic [2:0]       exc_id,
   output logic [VEC_W-1:0] vec_off
);

   localparam int MIN_VEC_W = OFS_W + OFS_SHIFT;
   localparam int VEC_LIM   = 1 << VEC_W;

   initial begin
      assert (VEC_W >= MIN_VEC_W)
         else $error("VEC_W too narrow for shifted offset");
      assert (NMI_AUTO < VEC_LIM && IRQ_AUTO < VEC_LIM)
         else $error("auto-vector does not fit VEC_W");
      assert (DBG_VEC < VEC_LIM && ILL_VEC < VEC_LIM && TRAP_VEC < VEC_LIM)
         else $error("internal vector does not fit VEC_W");
      assert (LVL_W >= 1) else $error("LVL_W must be positive");
   end

   logic                   irq_ok;
   logic [NUM_CLASSES-1:0] req_vec;
   logic                   any_req;
   exc_id_e                winner;
   logic [VEC_W-1:0]       vec_d;

   exc_irq_gate #(.LVL_W(LVL_W), .STRICT_GT(1'b1)) u_gate (
      .irq_req   (irq_req),
      .irq_level (irq_level),
      .sr_mask   (sr_mask),
      .irq_ok    (irq_ok)
   );

   // Bit index equals class number; class 3 has no source
   assign req_vec = {irq_ok, nmi_req, 1'b0, trap_req, ill_req, dbg_req};

   exc_prio_select #(.N(NUM_CLASSES)) u_sel (
      .req_vec (req_vec),
      .any_req (any_req),
      .winner  (winner)
   );

   exc_vec_mux #(
      .VEC_W(VEC_W), .OFS_W(OFS_W), .OFS_SHIFT(OFS_SHIFT),
      .DBG_VEC(DBG_VEC), .ILL_VEC(ILL_VEC), .TRAP_VEC(TRAP_VEC),
      .NMI_AUTO(NMI_AUTO), .IRQ_AUTO(IRQ_AUTO)
   ) u_vec (
      .sel         (winner),
      .nmi_autovec (nmi_autovec),
      .irq_autovec (irq_autovec),
      .irq_offset  (irq_offset),
      .vec         (vec_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take    <= 1'b0;
         exc_id  <= '0;
         vec_off <= '0;
      end else if (any_req) begin
         take    <= 1'b1;
         exc_id  <= winner;
         vec_off <= vec_d;
      end else begin
         take    <= 1'b0;
         exc_id  <= '0;
         vec_off <= '0;
      end
   end

   assert_dbg_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |=> (take && exc_id == 3'd0 && vec_off == VEC_W'(DBG_VEC)));

   assert_trap_over_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !dbg_req && !ill_req) |=> (take && exc_id == 3'd2));

   assert_nmi_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && nmi_autovec && !dbg_req && !ill_req && !trap_req)
      |=> (exc_id == 3'd4 && vec_off == VEC_W'(NMI_AUTO)));

   assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_req && !ill_req && !trap_req && !nmi_req && irq_level <= sr_mask)
      |=> !take);

   assert_idle_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_req && !ill_req && !trap_req && !nmi_req && !irq_req)
      |=> (!take && vec_off == '0));

   assert_no_class3_R10: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (exc_id != 3'd3 && exc_id <= 3'd5));

endmodule

// File: tb/exc_vector_arbiter_test.sv
`timescale 1ns/1ps
module exc_vector_arbiter_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       dbg_req, ill_req, trap_req, nmi_req, nmi_autovec;
   logic       irq_req, irq_autovec;
   logic [2:0] irq_level, sr_mask;
   logic [5:0] irq_offset;
   logic       take;
   logic [2:0] exc_id;
   logic [8:0] vec_off;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   bit  have_exp = 1'b0;
   int  e_take, e_id, e_vec;
   string e_req;

   always #2 clk = ~clk;

   exc_vector_arbiter uut (
      .clk(clk), .rst_n(rst_n),
      .dbg_req(dbg_req), .ill_req(ill_req), .trap_req(trap_req),
      .nmi_req(nmi_req), .nmi_autovec(nmi_autovec),
      .irq_req(irq_req), .irq_level(irq_level), .irq_autovec(irq_autovec),
      .irq_offset(irq_offset), .sr_mask(sr_mask),
      .take(take), .exc_id(exc_id), .vec_off(vec_off)
   );

   // Behavioural model: expected outputs one cycle after the inputs
   task automatic model();
      int ofs8;
      ofs8 = int'(irq_offset) * 8;
      if (dbg_req) begin
         e_take = 1; e_id = 0; e_vec = 'h040; e_req = "R2";
      end else if (ill_req) begin
         e_take = 1; e_id = 1; e_vec = 'h080; e_req = "R3";
      end else if (trap_req) begin
         e_take = 1; e_id = 2; e_vec = 'h0C0; e_req = "R4";
      end else if (nmi_req) begin
         e_take = 1; e_id = 4; e_vec = nmi_autovec ? 'h180 : ofs8; e_req = "R5/R7";
      end else if (irq_req && int'(irq_level) > int'(sr_mask)) begin
         e_take = 1; e_id = 5; e_vec = irq_autovec ? 'h1C0 : ofs8; e_req = "R6/R8";
      end else begin
         e_take = 0; e_id = 0; e_vec = 0; e_req = "R9";
      end
   endtask

   task automatic compare(string tag, int t, int id, int v);
      checks++;
      if (int'(take) != t || int'(exc_id) != id || int'(vec_off) != v) begin
         errors++;
         $display("FAIL %s: take/id/vec actual %0d/%0d/0x%0h expected %0d/%0d/0x%0h",
                  tag, take, exc_id, vec_off, t, id, v);
      end
      if (take && exc_id == 3'd3) begin
         checks++; errors++;
         $display("FAIL R10: exc_id actual 3 expected not 3");
      end
   endtask

   // One cycle: check the result of the previous set, then drive a new one
   task automatic apply(bit d, bit il, bit tr, bit n, bit na, bit iq,
                        int lvl, bit ia, int ofs, int msk);
      @(negedge clk);
      if (have_exp) compare(e_req, e_take, e_id, e_vec);
      dbg_req = d; ill_req = il; trap_req = tr; nmi_req = n; nmi_autovec = na;
      irq_req = iq; irq_level = 3'(lvl); irq_autovec = ia;
      irq_offset = 6'(ofs); sr_mask = 3'(msk);
      model();
      have_exp = 1'b1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog: cycles actual %0d expected below 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      dbg_req = 1; ill_req = 1; trap_req = 1; nmi_req = 1; nmi_autovec = 1;
      irq_req = 1; irq_level = 3'd7; irq_autovec = 1; irq_offset = 6'h3F; sr_mask = 3'd0;
      repeat (3) @(negedge clk);
      compare("R1", 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      dbg_req = 0; ill_req = 0; trap_req = 0; nmi_req = 0; irq_req = 0;
      @(negedge clk);
      compare("R1", 0, 0, 0);

      // Priority pairs (R2..R5)
      apply(1,1,1,1,1,1, 7,1,5,0);
      apply(0,1,1,1,1,1, 7,1,5,0);
      apply(0,0,1,1,1,1, 7,1,5,0);
      apply(0,0,0,1,1,1, 7,1,5,0);
      apply(0,0,0,1,0,1, 7,1,5,0);
      // Mask boundary (R6)
      apply(0,0,0,0,0,1, 3,1,9,3);
      apply(0,0,0,0,0,1, 4,1,9,3);
      apply(0,0,0,0,0,1, 7,0,9,7);
      apply(0,0,0,0,0,1, 7,0,6'h2A,6);
      apply(0,0,0,0,0,1, 0,0,1,0);
      // Idle and back-to-back strobes (R9)
      apply(0,0,0,0,0,0, 0,0,0,0);
      apply(0,0,1,0,0,0, 0,0,0,0);
      apply(0,0,1,0,0,0, 0,0,0,0);
      apply(0,0,0,0,0,0, 0,0,0,0);
      // Offset extremes for both external vectors (R7, R8)
      apply(0,0,0,1,0,0, 0,0,6'h3F,0);
      apply(0,0,0,0,0,1, 1,0,6'h3F,0);
      apply(0,0,0,1,0,0, 0,0,0,0);

      for (int k = 0; k < 600; k++) begin
         apply($urandom_range(0,7) == 0, $urandom_range(0,6) == 0,
               $urandom_range(0,5) == 0, $urandom_range(0,3) == 0,
               1'($urandom), 1'($urandom), int'($urandom_range(0,7)),
               1'($urandom), int'($urandom_range(0,63)), int'($urandom_range(0,7)));
      end
      apply(0,0,0,0,0,0, 0,0,0,0);
      @(negedge clk);
      compare(e_req, e_take, e_id, e_vec);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule